// File: doc/BRIEF.md
# In-Order Completion Queue

This block tracks instructions that have been dispatched but not yet retired. It keeps them in program order in a six-slot circular queue. A front end hands it up to two instructions per cycle, and each one carries a tag and a flag that marks it as a branch. Each instruction is told which slot it landed in. The execution units then report each slot as finished, and a report may carry an exception. The queue retires finished work strictly from the oldest entry, at most two entries per cycle. It raises a retire strobe and the tag for each entry it retires.

Two events disturb that flow.

- **Mispredicted branch.** A branch-resolution report that marks a branch slot as mispredicted removes every entry younger than that branch. The branch and all older entries stay.
- **Exception at the head.** If the oldest entry finishes with an exception, retirement stops at that entry. A small controller then moves from state `ST_RUN` to state `ST_EXC_FLUSH`. For that one cycle it presents the entry's tag on the exception output. At the end of the cycle it empties the whole queue and returns to `ST_RUN`.

The controller has two transitions only:
- `ST_RUN` goes to `ST_EXC_FLUSH` when the head has an exception pending.
- `ST_EXC_FLUSH` always goes back to `ST_RUN`.

Top module: `cmpl_queue`

## Requirements
- R1: After reset the queue is empty: `occupancy` is 0, `disp_idx` is 0, no retire strobe or exception is raised, and `disp_ready` is high.
- R2: Dispatch lane 0 takes the slot shown on `disp_idx`, and lane 1 takes the next slot. Lane 1 is used only when lane 0 is also valid, so `disp_valid` = 2'b10 allocates nothing.
- R3: The queue holds six entries. `disp_ready` is low whenever the number of lanes requested exceeds the free slots. No entry is allocated in that cycle.
- R4: An entry retires only when it has finished and every older entry has retired or retires in the same cycle. A finished entry behind an unfinished one waits.
- R5: At most two entries retire per cycle. `ret_valid[1]` is raised only together with `ret_valid[0]`, and lane 0 carries the older tag. Retirement takes effect at the next clock edge.
- R6: A head entry finished with an exception never retires. `disp_ready` drops in the cycle after the report. One cycle later `exc_valid` is high for one cycle with that entry's tag. After that cycle the queue is empty and `disp_idx` is 0.
- R7: `br_valid` with `br_mispredict` on an occupied slot whose branch flag is set removes every younger entry, and the next dispatch slot becomes the branch slot plus one. `disp_ready` is low during the resolving cycle. A resolution with `br_mispredict` low changes nothing.
- R8: Slot indices wrap from 5 to 0, so a two-lane dispatch starting at slot 5 uses slots 5 and 0.
- R9: A finish report for a slot that is not occupied is ignored. It does not mark a slot that a later dispatch fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 2 | Dispatch request per lane |
| disp_tag | input | 16 | Tag per lane, lane 0 in bits 7:0 |
| disp_branch | input | 2 | Branch flag per lane |
| disp_ready | output | 1 | Request accepted this cycle |
| disp_idx | output | 3 | Slot assigned to lane 0 |
| fin_valid | input | 1 | Finish report strobe |
| fin_idx | input | 3 | Slot that finished |
| fin_exc | input | 1 | Finished with an exception |
| br_valid | input | 1 | Branch resolution strobe |
| br_idx | input | 3 | Slot of the resolved branch |
| br_mispredict | input | 1 | Branch was mispredicted |
| ret_valid | output | 2 | Retire strobe per lane |
| ret_tag | output | 16 | Retired tag per lane, lane 0 in bits 7:0 |
| exc_valid | output | 1 | Exception at head reported |
| exc_tag | output | 8 | Tag of the excepting entry |
| occupancy | output | 3 | Entries held |

## Verification
Each result of this block is due at a fixed delay after its stimulus:

- **Dispatch and branch resolution.** Their effect shows on `occupancy` and `disp_idx` right after the clock edge that samples them.
- **Retire strobes.** These come from the stored finish flags without a further register. They are therefore visible in the cycle after the finishing edge, and the count drops one edge later.
- **Exception at the head.** The report is due one edge after the finish that sets it. The emptied queue is due one edge after that.

The bench applies every stimulus two time units after a rising edge. It checks combinational results one unit later, before the next edge. It checks registered results just after the edge that commits them.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;

    typedef enum logic [0:0] {
        ST_RUN       = 1'b0,
        ST_EXC_FLUSH = 1'b1
    } cq_state_e;

    typedef struct packed {
        logic done;
        logic exc;
        logic br;
    } cq_flags_t;

endpackage

// File: rtl/cmpl_ctrl_fsm.sv
module cmpl_ctrl_fsm
    import cmpl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic head_exc,
    output logic run_o,
    output logic flush_o
);

    cq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       state_d = head_exc ? ST_EXC_FLUSH : ST_RUN;
            ST_EXC_FLUSH: state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    always_comb begin
        run_o   = 1'b0;
        flush_o = 1'b0;
        unique case (state_q)
            ST_RUN:       run_o   = 1'b1;
            ST_EXC_FLUSH: flush_o = 1'b1;
            default:      run_o   = 1'b1;
        endcase
    end

endmodule

// File: rtl/cmpl_retire_sel.sv
module cmpl_retire_sel #(
    parameter int DEPTH = 6,
    parameter int LANES = 2,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input  logic [IDX_W-1:0]       head,
    input  logic [CNT_W-1:0]       count,
    input  logic [DEPTH-1:0]       done_v,
    input  logic [DEPTH-1:0]       exc_v,
    input  logic                   enable,
    input  logic                   lim_en,
    input  logic [CNT_W-1:0]       lim_age,
    output logic [LANES-1:0]       ret_mask,
    output logic [LANES*IDX_W-1:0] ret_idx,
    output logic [CNT_W-1:0]       nret
);

    always_comb begin
        logic ok;
        int   slot;
        int   n;
        ok = enable;
        n  = 0;
        for (int l = 0; l < LANES; l++) begin
            slot = (int'(head) + l) % DEPTH;
            ok = ok && (l < int'(count)) && done_v[slot] && !exc_v[slot]
                    && (!lim_en || l <= int'(lim_age));
            ret_mask[l] = ok;
            ret_idx[l*IDX_W +: IDX_W] = IDX_W'(slot);
            if (ok) n = n + 1;
        end
        nret = CNT_W'(n);
    end

endmodule

// File: rtl/cmpl_queue.sv
module cmpl_queue
    import cmpl_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int TAG_W = 8,
    parameter int LANES = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       disp_valid,
    input  logic [LANES*TAG_W-1:0] disp_tag,
    input  logic [LANES-1:0]       disp_branch,
    output logic                   disp_ready,
    output logic [IDX_W-1:0]       disp_idx,
    input  logic                   fin_valid,
    input  logic [IDX_W-1:0]       fin_idx,
    input  logic                   fin_exc,
    input  logic                   br_valid,
    input  logic [IDX_W-1:0]       br_idx,
    input  logic                   br_mispredict,
    output logic [LANES-1:0]       ret_valid,
    output logic [LANES*TAG_W-1:0] ret_tag,
    output logic                   exc_valid,
    output logic [TAG_W-1:0]       exc_tag,
    output logic [CNT_W-1:0]       occupancy
);

    localparam int SLOTS = 2 ** IDX_W;

    logic [TAG_W-1:0] tag_q  [DEPTH];
    cq_flags_t        flag_q [DEPTH];
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q, count_d;

    logic [SLOTS-1:0] inq;
    logic [DEPTH-1:0] done_v, exc_v;
    logic             head_exc, run, exc_flush, mispred, fire;
    logic [CNT_W-1:0] br_age, nret, ndisp;
    logic [LANES-1:0] lane_use, ret_mask;
    logic [LANES*IDX_W-1:0] ret_idx, wr_idx;

    // occupancy map and flag vectors
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            inq[i] = (i < DEPTH) &&
                     (((i + DEPTH - int'(head_q)) % DEPTH) < int'(count_q));
        end
        for (int i = 0; i < DEPTH; i++) begin
            done_v[i] = flag_q[i].done;
            exc_v[i]  = flag_q[i].exc;
        end
    end

    assign head_exc = (count_q != '0) && flag_q[head_q].exc;
    assign br_age   = CNT_W'((int'(br_idx) + DEPTH - int'(head_q)) % DEPTH);
    assign mispred  = run && !head_exc && br_valid && br_mispredict &&
                      inq[br_idx] && flag_q[br_idx].br;

    cmpl_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .head_exc (head_exc),
        .run_o    (run),
        .flush_o  (exc_flush)
    );

    cmpl_retire_sel #(
        .DEPTH (DEPTH),
        .LANES (LANES),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_sel (
        .head     (head_q),
        .count    (count_q),
        .done_v   (done_v),
        .exc_v    (exc_v),
        .enable   (run),
        .lim_en   (mispred),
        .lim_age  (br_age),
        .ret_mask (ret_mask),
        .ret_idx  (ret_idx),
        .nret     (nret)
    );

    // dispatch lanes: contiguous from lane 0
    always_comb begin
        logic go;
        int   n;
        go = 1'b1;
        n  = 0;
        for (int l = 0; l < LANES; l++) begin
            go = go && disp_valid[l];
            lane_use[l] = go;
            if (go) n = n + 1;
            wr_idx[l*IDX_W +: IDX_W] = IDX_W'((int'(tail_q) + l) % DEPTH);
        end
        ndisp = CNT_W'(n);
    end

    assign disp_ready = run && !head_exc && !mispred &&
                        (int'(ndisp) <= DEPTH - int'(count_q));
    assign fire = disp_ready && (ndisp != '0);

    always_comb begin
        int c;
        if (mispred) c = int'(br_age) + 1 - int'(nret);
        else         c = int'(count_q) + (fire ? int'(ndisp) : 0) - int'(nret);
        count_d = CNT_W'(c);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || exc_flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                flag_q[i] <= '0;
                tag_q[i]  <= '0;
            end
        end else begin
            if (fin_valid && inq[fin_idx]) begin
                flag_q[fin_idx].done <= 1'b1;
                flag_q[fin_idx].exc  <= fin_exc;
            end
            for (int l = 0; l < LANES; l++) begin
                if (ret_mask[l]) flag_q[ret_idx[l*IDX_W +: IDX_W]] <= '0;
            end
            for (int l = 0; l < LANES; l++) begin
                if (fire && lane_use[l]) begin
                    tag_q[wr_idx[l*IDX_W +: IDX_W]]  <= disp_tag[l*TAG_W +: TAG_W];
                    flag_q[wr_idx[l*IDX_W +: IDX_W]] <= '{done: 1'b0, exc: 1'b0,
                                                          br: disp_branch[l]};
                end
            end
            head_q  <= IDX_W'((int'(head_q) + int'(nret)) % DEPTH);
            count_q <= count_d;
            if (mispred)
                tail_q <= IDX_W'((int'(br_idx) + 1) % DEPTH);
            else if (fire)
                tail_q <= IDX_W'((int'(tail_q) + int'(ndisp)) % DEPTH);
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            ret_tag[l*TAG_W +: TAG_W] = tag_q[ret_idx[l*IDX_W +: IDX_W]];
        end
    end

    assign ret_valid = ret_mask;
    assign exc_valid = exc_flush;
    assign exc_tag   = tag_q[head_q];
    assign occupancy = count_q;
    assign disp_idx  = tail_q;

endmodule

// File: rtl/cmpl_queue_chk.sv
module cmpl_queue_chk #(
    parameter int DEPTH = 6,
    parameter int TAG_W = 8,
    parameter int LANES = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] disp_valid,
    input logic             disp_ready,
    input logic [LANES-1:0] ret_valid,
    input logic             exc_valid,
    input logic [CNT_W-1:0] occupancy
);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);

    a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occupancy) == DEPTH && disp_valid[0]) |-> !disp_ready);

    a_r5_lanes_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_valid + 1'b1) & ret_valid) == '0);

    a_r6_exc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (ret_valid == '0 && !disp_ready));

    a_r6_exc_empties: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (occupancy == '0 && !exc_valid));

endmodule

bind cmpl_queue cmpl_queue_chk #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W),
    .LANES (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .ret_valid  (ret_valid),
    .exc_valid  (exc_valid),
    .occupancy  (occupancy)
);

// File: tb/tb_cmpl_queue.sv
`timescale 1ns/1ps
module tb_cmpl_queue;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  disp_valid;
    logic [15:0] disp_tag;
    logic [1:0]  disp_branch;
    logic        disp_ready;
    logic [2:0]  disp_idx;
    logic        fin_valid;
    logic [2:0]  fin_idx;
    logic        fin_exc;
    logic        br_valid;
    logic [2:0]  br_idx;
    logic        br_mispredict;
    logic [1:0]  ret_valid;
    logic [15:0] ret_tag;
    logic        exc_valid;
    logic [7:0]  exc_tag;
    logic [2:0]  occupancy;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cmpl_queue dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_branch(disp_branch),
        .disp_ready(disp_ready), .disp_idx(disp_idx),
        .fin_valid(fin_valid), .fin_idx(fin_idx), .fin_exc(fin_exc),
        .br_valid(br_valid), .br_idx(br_idx), .br_mispredict(br_mispredict),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .exc_valid(exc_valid), .exc_tag(exc_tag), .occupancy(occupancy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_in();
        disp_valid = '0; disp_tag = '0; disp_branch = '0;
        fin_valid = 1'b0; fin_idx = '0; fin_exc = 1'b0;
        br_valid = 1'b0; br_idx = '0; br_mispredict = 1'b0;
    endtask

    // commit applied inputs at the next edge, then clear and settle
    task automatic step();
        #1;
        @(posedge clk);
        #1;
        idle_in();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_in();
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
    endtask

    task automatic disp(input int n, input int t0, input int t1, input bit b1 = 1'b0);
        disp_valid  = (n == 2) ? 2'b11 : (n == 1) ? 2'b01 : 2'b00;
        disp_tag    = {8'(t1), 8'(t0)};
        disp_branch = {b1, 1'b0};
        step();
    endtask

    task automatic fin(input int idx, input bit exc = 1'b0);
        fin_valid = 1'b1;
        fin_idx   = 3'(idx);
        fin_exc   = exc;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        disp_valid = 2'b11;
        #1;
        chk("R1", "occupancy", occupancy, 0);
        chk("R1", "disp_idx", disp_idx, 0);
        chk("R1", "ret_valid", ret_valid, 0);
        chk("R1", "exc_valid", exc_valid, 0);
        chk("R1", "disp_ready", disp_ready, 1);
        idle_in();
        #1;
    endtask

    task automatic t_dispatch();
        do_reset();
        disp(2, 8'h01, 8'h02);
        chk("R2", "occupancy after pair", occupancy, 2);
        chk("R2", "disp_idx after pair", disp_idx, 2);
        disp(1, 8'h03, 0);
        chk("R2", "occupancy after single", occupancy, 3);
        chk("R2", "disp_idx after single", disp_idx, 3);
        disp_valid = 2'b10;
        disp_tag   = 16'h0400;
        step();
        chk("R2", "lane1 alone ignored occupancy", occupancy, 3);
        chk("R2", "lane1 alone ignored disp_idx", disp_idx, 3);
    endtask

    task automatic t_capacity();
        do_reset();
        disp(2, 1, 2);
        disp(2, 3, 4);
        disp(1, 5, 0);
        chk("R3", "occupancy five", occupancy, 5);
        disp_valid = 2'b11;
        #1;
        chk("R3", "two requested one free", disp_ready, 0);
        step();
        chk("R3", "refused pair not taken", occupancy, 5);
        disp_valid = 2'b01;
        #1;
        chk("R3", "one requested one free", disp_ready, 1);
        step();
        chk("R3", "occupancy full", occupancy, 6);
        disp_valid = 2'b01;
        #1;
        chk("R3", "full refuses one", disp_ready, 0);
        step();
        chk("R3", "full stays six", occupancy, 6);
    endtask

    task automatic t_in_order();
        do_reset();
        disp(2, 8'h10, 8'h11);
        disp(1, 8'h12, 0);
        fin(1);
        chk("R4", "younger finished waits", ret_valid, 0);
        step();
        chk("R4", "nothing retired", occupancy, 3);
        fin(0);
        chk("R4", "both retire", ret_valid, 3);
        chk("R4", "lane0 tag", ret_tag[7:0], 8'h10);
        chk("R4", "lane1 tag", ret_tag[15:8], 8'h11);
        step();
        chk("R4", "occupancy after pair retire", occupancy, 1);
        fin(2);
        chk("R4", "last retires", ret_valid, 1);
        chk("R4", "last tag", ret_tag[7:0], 8'h12);
        step();
        chk("R4", "empty", occupancy, 0);
    endtask

    task automatic t_dual_limit();
        do_reset();
        disp(2, 8'h60, 8'h61);
        disp(1, 8'h62, 0);
        fin(2);
        fin(1);
        fin(0);
        chk("R5", "three done, two retire", ret_valid, 3);
        chk("R5", "lane0 older tag", ret_tag[7:0], 8'h60);
        chk("R5", "lane1 younger tag", ret_tag[15:8], 8'h61);
        step();
        chk("R5", "third next cycle", ret_valid, 1);
        chk("R5", "third tag", ret_tag[7:0], 8'h62);
        chk("R5", "one left", occupancy, 1);
        step();
        chk("R5", "drained", occupancy, 0);
    endtask

    task automatic t_exception();
        do_reset();
        disp(2, 8'h20, 8'h21);
        fin(1);
        fin(0, 1'b1);
        chk("R6", "no retire at exc head", ret_valid, 0);
        chk("R6", "exc not yet", exc_valid, 0);
        chk("R6", "occupancy held", occupancy, 2);
        disp_valid = 2'b01;
        #1;
        chk("R6", "dispatch refused", disp_ready, 0);
        step();
        chk("R6", "exc reported", exc_valid, 1);
        chk("R6", "exc tag", exc_tag, 8'h20);
        chk("R6", "no retire in exc cycle", ret_valid, 0);
        step();
        chk("R6", "exc one cycle", exc_valid, 0);
        chk("R6", "queue emptied", occupancy, 0);
        chk("R6", "pointer reset", disp_idx, 0);
    endtask

    task automatic t_mispredict();
        do_reset();
        disp(2, 8'h30, 8'h31, 1'b1);
        disp(2, 8'h32, 8'h33);
        br_valid = 1'b1;
        br_idx   = 3'd1;
        step();
        chk("R7", "correct prediction keeps occupancy", occupancy, 4);
        chk("R7", "correct prediction keeps disp_idx", disp_idx, 4);
        br_valid      = 1'b1;
        br_idx        = 3'd1;
        br_mispredict = 1'b1;
        disp_valid    = 2'b01;
        #1;
        chk("R7", "no dispatch while flushing", disp_ready, 0);
        step();
        chk("R7", "younger flushed", occupancy, 2);
        chk("R7", "tail after branch", disp_idx, 2);
        fin(1);
        fin(0);
        chk("R7", "survivors retire", ret_valid, 3);
        chk("R7", "survivor tag0", ret_tag[7:0], 8'h30);
        chk("R7", "survivor tag1", ret_tag[15:8], 8'h31);
        step();
        chk("R7", "empty after survivors", occupancy, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        disp(1, 8'h40, 0);
        fin(0);
        step();
        chk("R8", "head moved", occupancy, 0);
        chk("R8", "disp_idx one", disp_idx, 1);
        disp(2, 8'h41, 8'h42);
        disp(2, 8'h43, 8'h44);
        chk("R8", "disp_idx five", disp_idx, 5);
        disp(2, 8'h45, 8'h46);
        chk("R8", "wrapped disp_idx", disp_idx, 1);
        chk("R8", "full after wrap", occupancy, 6);
        fin(0);
        chk("R8", "slot0 is youngest", ret_valid, 0);
        fin(1);
        chk("R8", "head slot1 retires", ret_valid, 1);
        chk("R8", "head tag", ret_tag[7:0], 8'h41);
    endtask

    task automatic t_stale_finish();
        do_reset();
        disp(1, 8'h50, 0);
        fin(1);
        chk("R9", "stray finish no retire", ret_valid, 0);
        chk("R9", "stray finish occupancy", occupancy, 1);
        disp(1, 8'h51, 0);
        fin(0);
        chk("R9", "only head retires", ret_valid, 1);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_dispatch();
        t_capacity();
        t_in_order();
        t_dual_limit();
        t_exception();
        t_mispredict();
        t_wrap();
        t_stale_finish();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule